// File: doc/BRIEF.md
# Timer Compare/Capture I/O Channel

This block is one channel of a general-purpose timer. It holds a set of general registers (two by default, called A and B), each one configured through its own 4-bit mode field in a shared 8-bit control register. A register in compare mode watches the free-running counter supplied from outside the block. When the counter equals the register, the register drives its timer pin low, drives it high or toggles it. A register in capture mode copies the counter when a timing event arrives. The event is either an edge on its own timer pin, after synchronisation, or a count strobe from the neighbouring channel.

A mode write with an active compare code places the pin at a defined starting level on the next clock. Capture modes release the pin driver. The neighbouring-channel strobe is ignored while the neighbour runs from the undivided system clock, which is signalled on `nbr_fast`.

Top module: `tmr_io_chan`

## Requirements
- R1: After reset the control register reads 0x00, every general register reads 0, and every pin output and pin enable is 0. The control register can be written with any 8-bit value and reads back the same value.
- R2: Control bits 3..0 set the mode of register A, which drives pin index 0. Control bits 7..4 set the mode of register B, which drives pin index 1. Writing one field has no effect on the other register's pin.
- R3: The codes 0000 and 0100 keep the pin enable at 0. With either code, neither a mode write nor a compare match changes the pin output.
- R4: After a write of code 0001, 0010 or 0011, the pin reads 0 on the next clock. After a write of code 0101, 0110 or 0111, the pin reads 1 on the next clock. In both cases the pin enable reads 1.
- R5: In compare mode, a counter equal to the register acts on the pin at the next clock edge. Low code bits 01 drive 0, 10 drive 1 and 11 toggle.
- R6: A compare match acts once for each counter value. If the counter stays at the matching value, a toggle happens only once. The counter must leave that value and come back before the pin toggles again.
- R7: Pin capture reads the pin through a 2-flop synchroniser and an edge detector, and loads the counter on the third clock edge after the pin changes. Code 1000 captures on rising edges, 1001 on falling edges, and 1010 or 1011 on both edges.
- R8: Codes 11xx load the counter on the clock edge that ends a cycle with `nbr_evt`=1 and `nbr_fast`=0. With `nbr_fast`=1 no capture takes place.
- R9: When a capture and a bus write hit the same register in the same cycle, the captured counter value is stored.
- R10: In every capture mode (mode bit 3 = 1) the pin enable is 0.
- R11: A bus write to a general register with no capture in that cycle stores the written data. This works in any mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| gr_we | input | 2 | Per-register write strobe (bit 0 = A) |
| gr_wdata | input | 16 | General register write data |
| gr_rdata | output | 32 | General registers, A in bits 15..0, B in bits 31..16 |
| cnt | input | 16 | Free-running counter value |
| nbr_evt | input | 1 | Neighbouring channel count strobe |
| nbr_fast | input | 1 | Neighbour counts on the undivided clock |
| tpin_in | input | 2 | Sampled timer pin levels |
| tpin_out | output | 2 | Timer pin output levels |
| tpin_oe | output | 2 | Timer pin output enables |

## Verification
The compare function is tested with several inputs: a counter that jumps onto the register value, one that stays there, and one that leaves and returns. These separate a single set or clear from a toggle, and a toggle that fires once from one that fires again on every cycle. Capture is tested with rising and falling pin edges against each edge code, which shows whether the edge selection works and whether the synchroniser latency is right. The neighbouring-channel strobe is driven with and without `nbr_fast`, and once in the same cycle as a bus write, to check suppression and the priority between capture and write.

// File: rtl/tmr_io_pkg.sv
package tmr_io_pkg;

   localparam int FLD_W = 4;

   typedef enum logic [1:0] {
      ACT_NONE = 2'b00,
      ACT_CLR  = 2'b01,
      ACT_SET  = 2'b10,
      ACT_TGL  = 2'b11
   } oc_act_e;

   typedef enum logic [2:0] {
      SRC_OFF  = 3'd0,
      SRC_RISE = 3'd1,
      SRC_FALL = 3'd2,
      SRC_BOTH = 3'd3,
      SRC_NBR  = 3'd4
   } cap_src_e;

   typedef struct packed {
      logic     is_cap;
      logic     init_lvl;
      oc_act_e  act;
      cap_src_e src;
   } mode_t;

   function automatic mode_t decode_mode(input logic [FLD_W-1:0] code);
      mode_t m;
      m.is_cap   = code[3];
      m.init_lvl = code[2];
      m.act      = code[3] ? ACT_NONE : oc_act_e'(code[1:0]);
      if (!code[3])          m.src = SRC_OFF;
      else if (code[2])      m.src = SRC_NBR;
      else if (code[1])      m.src = SRC_BOTH;
      else if (code[0])      m.src = SRC_FALL;
      else                   m.src = SRC_RISE;
      return m;
   endfunction

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   localparam int CHAIN_W = STAGES + 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tmr_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN_W-2:0], pin};
   end

   logic cur, prev;
   assign cur  = chain_q[STAGES-1];
   assign prev = chain_q[STAGES];
   assign rise = cur & ~prev;
   assign fall = ~cur & prev;
endmodule

// File: rtl/tmr_gr_unit.sv
module tmr_gr_unit
   import tmr_io_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FLD_W-1:0] fld,
   input  logic             fld_wr,
   input  logic [FLD_W-1:0] fld_new,
   input  logic [CW-1:0]    cnt,
   input  logic             gr_we,
   input  logic [CW-1:0]    gr_wdata,
   input  logic             pin_rise,
   input  logic             pin_fall,
   input  logic             nbr_hit,
   output logic [CW-1:0]    gr_q,
   output logic             pin_out,
   output logic             pin_oe
);
   mode_t m;
   assign m = decode_mode(fld);

   logic cap_evt;
   always_comb begin
      unique case (m.src)
         SRC_RISE: cap_evt = pin_rise;
         SRC_FALL: cap_evt = pin_fall;
         SRC_BOTH: cap_evt = pin_rise | pin_fall;
         SRC_NBR:  cap_evt = nbr_hit;
         default:  cap_evt = 1'b0;
      endcase
   end

   logic          fired_q;
   logic [CW-1:0] fire_cnt_q;
   logic          match, cmp_evt;
   assign match   = !m.is_cap && (cnt == gr_q);
   assign cmp_evt = match && !(fired_q && (fire_cnt_q == cnt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gr_q <= '0;
      end else if (cap_evt) begin
         gr_q <= cnt;
      end else if (gr_we) begin
         gr_q <= gr_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fired_q    <= 1'b0;
         fire_cnt_q <= '0;
      end else if (cmp_evt) begin
         fired_q    <= 1'b1;
         fire_cnt_q <= cnt;
      end else if (fired_q && (fire_cnt_q != cnt)) begin
         fired_q    <= 1'b0;
      end
   end

   logic init_wr;
   assign init_wr = fld_wr && !fld_new[3] && (fld_new[1:0] != 2'b00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_out <= 1'b0;
      end else if (init_wr) begin
         pin_out <= fld_new[2];
      end else if (cmp_evt) begin
         unique case (m.act)
            ACT_CLR: pin_out <= 1'b0;
            ACT_SET: pin_out <= 1'b1;
            ACT_TGL: pin_out <= ~pin_out;
            default: pin_out <= pin_out;
         endcase
      end
   end

   assign pin_oe = !m.is_cap && (m.act != ACT_NONE);
endmodule

// File: rtl/tmr_io_chan.sv
module tmr_io_chan
   import tmr_io_pkg::*;
#(
   parameter int CW          = 16,
   parameter int NGR         = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_NBR     = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ctl_we,
   input  logic [FLD_W*NGR-1:0]   ctl_wdata,
   output logic [FLD_W*NGR-1:0]   ctl_rdata,
   input  logic [NGR-1:0]         gr_we,
   input  logic [CW-1:0]          gr_wdata,
   output logic [NGR*CW-1:0]      gr_rdata,
   input  logic [CW-1:0]          cnt,
   input  logic                   nbr_evt,
   input  logic                   nbr_fast,
   input  logic [NGR-1:0]         tpin_in,
   output logic [NGR-1:0]         tpin_out,
   output logic [NGR-1:0]         tpin_oe
);
   localparam int CTL_W = FLD_W * NGR;

   generate
      if (CW < 2)  begin : g_bad_cw  $error("tmr_io_chan: CW too small"); end
      if (NGR < 1) begin : g_bad_ngr $error("tmr_io_chan: NGR must be >= 1"); end
   endgenerate

   logic [CTL_W-1:0] ctl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_we) ctl_q <= ctl_wdata;
   end
   assign ctl_rdata = ctl_q;

   logic nbr_hit;
   generate
      if (HAS_NBR) begin : g_nbr
         assign nbr_hit = nbr_evt & ~nbr_fast;
      end else begin : g_no_nbr
         assign nbr_hit = 1'b0;
      end
   endgenerate

   generate
      for (genvar g = 0; g < NGR; g++) begin : g_gr
         logic rise, fall;

         tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (tpin_in[g]),
            .rise  (rise),
            .fall  (fall)
         );

         tmr_gr_unit #(.CW(CW)) u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .fld      (ctl_q[g*FLD_W +: FLD_W]),
            .fld_wr   (ctl_we),
            .fld_new  (ctl_wdata[g*FLD_W +: FLD_W]),
            .cnt      (cnt),
            .gr_we    (gr_we[g]),
            .gr_wdata (gr_wdata),
            .pin_rise (rise),
            .pin_fall (fall),
            .nbr_hit  (nbr_hit),
            .gr_q     (gr_rdata[g*CW +: CW]),
            .pin_out  (tpin_out[g]),
            .pin_oe   (tpin_oe[g])
         );
      end
   endgenerate
endmodule

// File: rtl/tmr_io_chan_chk.sv
module tmr_io_chan_chk #(
   parameter int CW      = 16,
   parameter int NGR     = 2,
   parameter bit HAS_NBR = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_we,
   input logic [4*NGR-1:0]  ctl_wdata,
   input logic [4*NGR-1:0]  ctl_rdata,
   input logic [NGR-1:0]    gr_we,
   input logic [CW-1:0]     gr_wdata,
   input logic [NGR*CW-1:0] gr_rdata,
   input logic [CW-1:0]     cnt,
   input logic              nbr_evt,
   input logic              nbr_fast,
   input logic [NGR-1:0]    tpin_out,
   input logic [NGR-1:0]    tpin_oe
);
   generate
      for (genvar g = 0; g < NGR; g++) begin : g_chk
         AST_INIT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_we && !ctl_wdata[4*g+3] && (ctl_wdata[4*g +: 2] != 2'b00))
            |=> (tpin_out[g] == $past(ctl_wdata[4*g+2]) && tpin_oe[g])); // R4

         AST_OC_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctl_rdata[4*g+3] && ctl_rdata[4*g +: 2] == 2'b00) |-> !tpin_oe[g]); // R3

         AST_CAP_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
            ctl_rdata[4*g+3] |-> !tpin_oe[g]); // R10

         AST_BUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (gr_we[g] && !ctl_rdata[4*g+3])
            |=> (gr_rdata[g*CW +: CW] == $past(gr_wdata))); // R11

         if (HAS_NBR) begin : g_nbr
            AST_NBR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
               (ctl_rdata[4*g+3 -: 2] == 2'b11 && nbr_evt && !nbr_fast)
               |=> (gr_rdata[g*CW +: CW] == $past(cnt))); // R9

            AST_NBR_FAST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
               (ctl_rdata[4*g+3 -: 2] == 2'b11 && nbr_fast && !gr_we[g])
               |=> $stable(gr_rdata[g*CW +: CW])); // R8
         end
      end
   endgenerate
endmodule

bind tmr_io_chan tmr_io_chan_chk #(.CW(CW), .NGR(NGR), .HAS_NBR(HAS_NBR)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_we    (ctl_we),
   .ctl_wdata (ctl_wdata),
   .ctl_rdata (ctl_rdata),
   .gr_we     (gr_we),
   .gr_wdata  (gr_wdata),
   .gr_rdata  (gr_rdata),
   .cnt       (cnt),
   .nbr_evt   (nbr_evt),
   .nbr_fast  (nbr_fast),
   .tpin_out  (tpin_out),
   .tpin_oe   (tpin_oe)
);

// File: tb/sim_tmr_io_chan.sv
`timescale 1ns/1ps
module sim_tmr_io_chan;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [7:0]  ctl_wdata = '0;
   logic [7:0]  ctl_rdata;
   logic [1:0]  gr_we = '0;
   logic [15:0] gr_wdata = '0;
   logic [31:0] gr_rdata;
   logic [15:0] cnt = '0;
   logic        nbr_evt = 1'b0;
   logic        nbr_fast = 1'b0;
   logic [1:0]  tpin_in = '0;
   logic [1:0]  tpin_out;
   logic [1:0]  tpin_oe;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   tmr_io_chan u0 (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .gr_we(gr_we), .gr_wdata(gr_wdata),
      .gr_rdata(gr_rdata), .cnt(cnt), .nbr_evt(nbr_evt), .nbr_fast(nbr_fast),
      .tpin_in(tpin_in), .tpin_out(tpin_out), .tpin_oe(tpin_oe)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      ctl_we = 1'b1; ctl_wdata = v;
      tick();
      ctl_we = 1'b0;
   endtask

   task automatic wr_gr(input int idx, input logic [15:0] v);
      gr_we = '0; gr_we[idx] = 1'b1; gr_wdata = v;
      tick();
      gr_we = '0;
   endtask

   task automatic t_reset();
      chk("R1", "ctl after reset", ctl_rdata, 8'h00);
      chk("R1", "gr after reset", gr_rdata, 32'h0);
      chk("R1", "pin out after reset", tpin_out, 2'b00);
      chk("R1", "pin oe after reset", tpin_oe, 2'b00);
   endtask

   task automatic t_ctl_rw();
      wr_ctl(8'h9D);
      chk("R1", "ctl readback", ctl_rdata, 8'h9D);
      wr_ctl(8'h00);
      chk("R1", "ctl cleared", ctl_rdata, 8'h00);
   endtask

   task automatic t_bus_write();
      wr_gr(0, 16'd100);
      wr_gr(1, 16'd200);
      chk("R11", "gr A write", gr_rdata[15:0], 16'd100);
      chk("R11", "gr B write", gr_rdata[31:16], 16'd200);
   endtask

   task automatic t_oc_set();
      cnt = 16'd5; tick();
      wr_ctl(8'h02);
      chk("R4", "A init low", tpin_out[0], 1'b0);
      chk("R4", "A oe on", tpin_oe[0], 1'b1);
      chk("R2", "B untouched by A field", tpin_oe[1], 1'b0);
      cnt = 16'd100; tick();
      chk("R5", "A set on match", tpin_out[0], 1'b1);
   endtask

   task automatic t_oc_toggle();
      cnt = 16'd5; tick();
      wr_ctl(8'h03);
      chk("R4", "A toggle-mode init low", tpin_out[0], 1'b0);
      cnt = 16'd100; tick();
      chk("R5", "A toggled on match", tpin_out[0], 1'b1);
      tick(3);
      chk("R6", "no retoggle while held", tpin_out[0], 1'b1);
      cnt = 16'd101; tick();
      cnt = 16'd100; tick();
      chk("R6", "toggle on return", tpin_out[0], 1'b0);
   endtask

   task automatic t_oc_b();
      cnt = 16'd5; tick();
      wr_ctl(8'h50);
      chk("R4", "B init high", tpin_out[1], 1'b1);
      chk("R2", "A oe off for code 0000", tpin_oe[0], 1'b0);
      cnt = 16'd200; tick();
      chk("R5", "B cleared on match", tpin_out[1], 1'b0);
      cnt = 16'd5; tick();
      wr_ctl(8'h70);
      chk("R4", "B toggle-mode init high", tpin_out[1], 1'b1);
      cnt = 16'd200; tick();
      chk("R5", "B toggled on match", tpin_out[1], 1'b0);
   endtask

   task automatic t_oc_off();
      cnt = 16'd5; tick();
      wr_ctl(8'h40);
      chk("R3", "code 0100 oe off", tpin_oe[1], 1'b0);
      chk("R3", "code 0100 write keeps pin", tpin_out[1], 1'b0);
      cnt = 16'd200; tick(2);
      chk("R3", "code 0100 match no action", tpin_out[1], 1'b0);
   endtask

   task automatic t_cap_rise();
      cnt = 16'h0000;
      wr_ctl(8'h08);
      chk("R10", "capture mode oe off", tpin_oe[0], 1'b0);
      cnt = 16'h1234; tpin_in[0] = 1'b1;
      tick(2);
      chk("R7", "no capture before 3rd edge", gr_rdata[15:0], 16'd100);
      tick();
      chk("R7", "rising capture", gr_rdata[15:0], 16'h1234);
      cnt = 16'h2222; tpin_in[0] = 1'b0; tick(4);
      chk("R7", "falling ignored in 1000", gr_rdata[15:0], 16'h1234);
   endtask

   task automatic t_cap_fall();
      wr_ctl(8'h09);
      cnt = 16'h3333; tpin_in[0] = 1'b1; tick(4);
      chk("R7", "rising ignored in 1001", gr_rdata[15:0], 16'h1234);
      tpin_in[0] = 1'b0; tick(3);
      chk("R7", "falling capture", gr_rdata[15:0], 16'h3333);
   endtask

   task automatic t_cap_both();
      wr_ctl(8'h0A);
      cnt = 16'h4444; tpin_in[0] = 1'b1; tick(3);
      chk("R7", "both: rising", gr_rdata[15:0], 16'h4444);
      cnt = 16'h5555; tpin_in[0] = 1'b0; tick(3);
      chk("R7", "both: falling", gr_rdata[15:0], 16'h5555);
   endtask

   task automatic t_nbr();
      wr_ctl(8'h0C);
      chk("R10", "nbr capture oe off", tpin_oe[0], 1'b0);
      cnt = 16'h0777; nbr_evt = 1'b1; tick();
      nbr_evt = 1'b0;
      chk("R8", "nbr capture", gr_rdata[15:0], 16'h0777);
      cnt = 16'h0888; nbr_fast = 1'b1; nbr_evt = 1'b1; tick();
      nbr_evt = 1'b0; nbr_fast = 1'b0;
      chk("R8", "nbr_fast suppresses", gr_rdata[15:0], 16'h0777);
   endtask

   task automatic t_prio();
      cnt = 16'h0999; nbr_evt = 1'b1;
      wr_gr(0, 16'hBEEF);
      nbr_evt = 1'b0;
      chk("R9", "capture beats write", gr_rdata[15:0], 16'h0999);
      wr_gr(0, 16'h1111);
      chk("R11", "write in capture mode", gr_rdata[15:0], 16'h1111);
   endtask

   task automatic finish_up();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_ctl_rw();
      t_bus_write();
      t_oc_set();
      t_oc_toggle();
      t_oc_b();
      t_oc_off();
      t_cap_rise();
      t_cap_fall();
      t_cap_both();
      t_nbr();
      t_prio();
      finish_up();
   end
endmodule